// File: doc/BRIEF.md
# Dual-Mode Framed Serial Command Receiver

This block takes 16-bit command words from a three-wire serial port: a frame sync line, a serial clock and a data line. It runs on a fast system clock. All three serial inputs pass through synchronizers, and their edges are detected from the synchronized samples. Data is sampled on each falling serial-clock edge, most significant bit first. When a word is complete, it appears on a parallel bus together with a one-cycle valid strobe, so that a downstream decoder can act on it.

A mode input selects between two framing rules.

- **Controller framing:** frame sync must stay low across all sixteen bits. The word is committed only when frame sync returns high. A frame sync that rises too early cancels the transfer and raises an abort strobe.
- **Processor framing:** frame sync may be a short low pulse, and the word is committed as soon as the sixteenth bit arrives. A frame start counts only if at least one falling serial-clock edge was seen while frame sync was high.

A daisy-chain output repeats the sampled data sixteen falling edges later, so that several receivers can share one bus. When the chain is disabled, this output is held low.

Top module: `dual_frame_rx`

## Requirements
- R1: A falling edge of frame sync starts a frame. The next 16 falling serial-clock edges shift data in MSB first. A committed word appears on `word_o` with `word_valid_o` high for exactly one system cycle, and `word_o` changes at no other time.
- R2: With `mode_i`=1 (controller framing), a complete 16-bit frame is not committed before frame sync rises; it is committed on that rising edge.
- R3: With `mode_i`=1, if frame sync rises before the 16th falling edge of the frame, `abort_o` pulses for one cycle, no word is committed, and `word_o` keeps its previous value.
- R4: With `mode_i`=1, falling serial-clock edges after the 16th in a frame do not alter the word that is committed.
- R5: With `mode_i`=0 (processor framing), the word is committed right after the 16th falling edge, even if frame sync returned high earlier in the frame. A rising frame sync never aborts in this mode.
- R6: With `mode_i`=0, a frame-sync falling edge is accepted only if a falling serial-clock edge occurred while frame sync was high after the previous frame-sync fall (or after reset). Otherwise the frame is ignored: no valid strobe and no abort strobe.
- R7: With `chain_en_i`=1, `dout_o` between falling edges n and n+1 equals the data bit sampled at falling edge n-15 (counting from reset), and 0 while fewer than 16 edges have occurred. The delay line shifts on every falling edge, whether or not a frame is active.
- R8: With `chain_en_i`=0, `dout_o` is low.
- R9: After reset, `word_o` is 0, and `word_valid_o`, `abort_o` and `dout_o` are 0.
- R10: `word_valid_o` and `abort_o` are single-cycle pulses and are never high together.
- R11: Every accepted frame-sync falling edge restarts the bit count, so a frame restarted part-way through commits only the 16 bits that follow the last start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = controller framing, 0 = processor framing |
| chain_en_i | input | 1 | Enables the daisy-chain output |
| sclk_i | input | 1 | Serial clock, idles high |
| fs_i | input | 1 | Frame sync, active low |
| din_i | input | 1 | Serial data |
| word_o | output | 16 | Last committed word |
| word_valid_o | output | 1 | One-cycle strobe on commit |
| abort_o | output | 1 | One-cycle strobe on a cancelled controller-mode frame |
| dout_o | output | 1 | Daisy-chain data, delayed by 16 falling edges |

## Verification
A wrong bit counter or a lost priming flag shows up within one frame. Either the valid strobe is missing or extra, or the word is shifted by one or more bit positions, and this is seen a few system cycles after the final falling edge or the frame-sync rise. A fault in the chain delay line shows on `dout_o` about three system cycles after the falling edge that moves the bad bit to the tap, and it is compared against the history of sampled bits after every edge. Frames that are aborted, unprimed or restarted check that no state from an abandoned frame leaks into the next committed word.

// File: rtl/dual_frame_rx_pkg.sv
package dual_frame_rx_pkg;
  typedef enum logic {
    MODE_DSP = 1'b0,
    MODE_MCU = 1'b1
  } frame_mode_e;

  // bit positions of the synchronized serial lines
  localparam int unsigned LINE_DIN  = 0;
  localparam int unsigned LINE_SCLK = 1;
  localparam int unsigned LINE_FS   = 2;
  localparam int unsigned LINE_NUM  = 3;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= {STAGES{IDLE[g]}};
        prev_q <= IDLE[g];
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
        prev_q <= pipe_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign rise_o[g] = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~pipe_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/frx_framer.sv
module frx_framer
  import dual_frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  frame_mode_e       mode_i,
  input  logic              sclk_fall_i,
  input  logic              fs_fall_i,
  input  logic              fs_rise_i,
  input  logic              fs_lvl_i,
  input  logic              din_lvl_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              abort_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              active_q, active_d;
  logic              primed_q, primed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              abort_q, abort_d;
  logic              full;
  logic [WORD_W-1:0] sr_shift;

  assign full     = (cnt_q == CNT_FULL);
  assign sr_shift = {sr_q[WORD_W-2:0], din_lvl_i};

  always_comb begin
    active_d = active_q;
    primed_d = primed_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    abort_d  = 1'b0;
    if (fs_fall_i) begin
      // processor framing accepts a start only after a priming edge
      active_d = (mode_i == MODE_MCU) || primed_q;
      primed_d = 1'b0;
      cnt_d    = '0;
    end else begin
      if (sclk_fall_i && fs_lvl_i) primed_d = 1'b1;
      if (sclk_fall_i && active_q && !full) begin
        sr_d  = sr_shift;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST && mode_i == MODE_DSP) begin
          active_d = 1'b0;
          valid_d  = 1'b1;
          word_d   = sr_shift;
        end
      end
      if (fs_rise_i && active_q && mode_i == MODE_MCU) begin
        active_d = 1'b0;
        if (full) begin
          valid_d = 1'b1;
          word_d  = sr_q;
        end else begin
          abort_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      primed_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      primed_q <= primed_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
      word_q   <= word_d;
      valid_q  <= valid_d;
      abort_q  <= abort_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/frx_chain.sv
module frx_chain #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic bit_i,
  input  logic en_i,
  output logic dout_o
);
  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      line_q <= '0;
    else if (shift_i) line_q <= {line_q[DEPTH-2:0], bit_i};
  end

  assign dout_o = en_i & line_q[DEPTH-1];
endmodule

// File: rtl/dual_frame_rx.sv
module dual_frame_rx
  import dual_frame_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CHAIN_DEPTH = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              chain_en_i,
  input  logic              sclk_i,
  input  logic              fs_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              abort_o,
  output logic              dout_o
);
  localparam logic [LINE_NUM-1:0] LINE_IDLE = LINE_NUM'((1 << LINE_SCLK) | (1 << LINE_FS));

  logic [LINE_NUM-1:0] raw, lvl, rise, fall;
  logic                sclk_fall, fs_fall, fs_rise, fs_lvl, din_lvl;
  frame_mode_e         mode;

  assign raw[LINE_DIN]  = din_i;
  assign raw[LINE_SCLK] = sclk_i;
  assign raw[LINE_FS]   = fs_i;

  frx_sync #(
    .WIDTH (LINE_NUM),
    .STAGES(SYNC_STAGES),
    .IDLE  (LINE_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sclk_fall = fall[LINE_SCLK];
  assign fs_fall   = fall[LINE_FS];
  assign fs_rise   = rise[LINE_FS];
  assign fs_lvl    = lvl[LINE_FS];
  assign din_lvl   = lvl[LINE_DIN];
  assign mode      = frame_mode_e'(mode_i);

  frx_framer #(.WORD_W(WORD_W)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .sclk_fall_i(sclk_fall),
    .fs_fall_i  (fs_fall),
    .fs_rise_i  (fs_rise),
    .fs_lvl_i   (fs_lvl),
    .din_lvl_i  (din_lvl),
    .word_o     (word_o),
    .valid_o    (word_valid_o),
    .abort_o    (abort_o)
  );

  frx_chain #(.DEPTH(CHAIN_DEPTH)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_fall),
    .bit_i  (din_lvl),
    .en_i   (chain_en_i),
    .dout_o (dout_o)
  );
endmodule

// File: rtl/dual_frame_rx_chk.sv
module dual_frame_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              chain_en_i,
  input logic              fs_rise_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              abort_o,
  input logic              dout_o
);
  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  assert_abort_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_o && abort_o));

  assert_word_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> word_valid_o);

  assert_abort_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(fs_rise_i) && $past(mode_i)));

  assert_mcu_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && $past(mode_i)) |-> $past(fs_rise_i));

  assert_chain_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |-> !dout_o);
endmodule

bind dual_frame_rx dual_frame_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .chain_en_i  (chain_en_i),
  .fs_rise_i   (fs_rise),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .abort_o     (abort_o),
  .dout_o      (dout_o)
);

// File: tb/dual_frame_rx_tb.sv
`timescale 1ns/1ps
module dual_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b1;
  logic        chain_en = 1'b0;
  logic        sclk = 1'b1;
  logic        fs = 1'b1;
  logic        din = 1'b0;
  logic [15:0] word;
  logic        word_valid, abort_s, dout;

  int total = 0;
  int fails = 0;
  int vcnt = 0;
  int acnt = 0;

  // requirement model
  int          ev = 0;
  int          ea = 0;
  logic [15:0] ew = '0;
  logic        m_active = 1'b0;
  logic        primed_m = 1'b0;
  int          m_cnt = 0;
  logic [15:0] m_sr = '0;
  logic        hist [0:4095];
  int          nfall = 0;

  always #2.5 clk = ~clk;

  dual_frame_rx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .chain_en_i  (chain_en),
    .sclk_i      (sclk),
    .fs_i        (fs),
    .din_i       (din),
    .word_o      (word),
    .word_valid_o(word_valid),
    .abort_o     (abort_s),
    .dout_o      (dout)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) vcnt++;
      if (abort_s) acnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_dout();
    if (!chain_en) return 1'b0;
    if (nfall < 16) return 1'b0;
    return hist[nfall-15];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    din = b;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    nfall++;
    hist[nfall] = b;
    if (fs) primed_m = 1'b1;
    if (m_active && m_cnt < 16) begin
      m_sr = {m_sr[14:0], b};
      m_cnt++;
      if (m_cnt == 16 && !mode) begin
        m_active = 1'b0;
        ev++;
        ew = m_sr;
      end
    end
    repeat (4) @(negedge clk);
    if (chain_en) chk("R7 chain tap", 32'(dout), 32'(exp_dout()));
    else          chk("R8 chain off", 32'(dout), 32'(exp_dout()));
    sclk = 1'b1;
  endtask

  task automatic set_fs(input logic v);
    @(negedge clk);
    fs = v;
    if (!v) begin
      m_active = mode || primed_m;
      primed_m = 1'b0;
      m_cnt = 0;
    end else if (mode && m_active) begin
      m_active = 1'b0;
      if (m_cnt == 16) begin
        ev++;
        ew = m_sr;
      end else begin
        ea++;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int from, input int n);
    for (int i = from; i < from + n; i++) send_bit(w[15-i]);
  endtask

  task automatic frame_checks(input string req);
    repeat (8) @(negedge clk);
    chk({req, " valid count"}, 32'(vcnt), 32'(ev));
    chk({req, " abort count"}, 32'(acnt), 32'(ea));
    chk({req, " word"}, 32'(word), 32'(ew));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 word", 32'(word), 32'h0);
    chk("R9 valid", 32'(word_valid), 32'h0);
    chk("R9 abort", 32'(abort_s), 32'h0);
    chk("R9 dout", 32'(dout), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after release", 32'(word_valid | abort_s | dout), 32'h0);

    // R1 R2: controller framing, commit waits for frame-sync rise
    chain_en = 1'b1;
    mode = 1'b1;
    set_fs(1'b0);
    send_bits(16'hA5C3, 0, 16);
    repeat (6) @(negedge clk);
    chk("R2 no commit before rise", 32'(vcnt), 32'(ev));
    set_fs(1'b1);
    frame_checks("R1 R2 controller frame");
    chk("R1 literal word", 32'(word), 32'hA5C3);

    // R4: extra edge after 16 bits ignored
    set_fs(1'b0);
    send_bits(16'h3C5A, 0, 16);
    send_bit(1'b1);
    set_fs(1'b1);
    frame_checks("R4 extra edge");
    chk("R4 literal word", 32'(word), 32'h3C5A);

    // R3: early frame-sync rise cancels
    set_fs(1'b0);
    send_bits(16'hFFFF, 0, 9);
    set_fs(1'b1);
    frame_checks("R3 abort");
    chk("R3 word kept", 32'(word), 32'h3C5A);

    // R6: processor framing without priming edge is ignored
    mode = 1'b0;
    set_fs(1'b0);
    send_bits(16'h1234, 0, 16);
    set_fs(1'b1);
    frame_checks("R6 unprimed");
    chk("R6 word kept", 32'(word), 32'h3C5A);

    // R5: primed, frame sync returns high after 3 bits
    send_bit(1'b0);
    set_fs(1'b0);
    send_bits(16'hC0DE, 0, 3);
    set_fs(1'b1);
    send_bits(16'hC0DE, 3, 13);
    frame_checks("R5 short sync pulse");
    chk("R5 literal word", 32'(word), 32'hC0DE);

    // R11: restart part-way, only last 16 bits count
    set_fs(1'b0);
    send_bits(16'hFFFF, 0, 5);
    set_fs(1'b1);
    send_bits(16'h0000, 0, 2);
    set_fs(1'b0);
    send_bits(16'h5EA1, 0, 16);
    set_fs(1'b1);
    frame_checks("R11 restart");
    chk("R11 literal word", 32'(word), 32'h5EA1);

    // R8: chain disabled for a full frame
    chain_en = 1'b0;
    mode = 1'b1;
    set_fs(1'b0);
    send_bits(16'hFFFF, 0, 16);
    set_fs(1'b1);
    frame_checks("R8 chain off frame");

    // randomized frames
    for (int f = 0; f < 40; f++) begin
      int kind;
      int k;
      @(negedge clk);
      mode = 1'($urandom % 2);
      chain_en = 1'($urandom % 2);
      w = 16'($urandom);
      kind = $urandom % 4;
      if (mode) begin
        k = (kind == 3) ? int'($urandom % 16) : 16;
        set_fs(1'b0);
        send_bits(w, 0, k);
        if (kind == 2) send_bit(1'($urandom % 2));
        set_fs(1'b1);
        frame_checks("R1 R3 R4 random controller");
      end else begin
        if (kind != 3 && !primed_m) send_bit(1'($urandom % 2));
        k = (kind == 1) ? int'(1 + $urandom % 15) : 16;
        set_fs(1'b0);
        send_bits(w, 0, k);
        set_fs(1'b1);
        if (k < 16) send_bits(w, k, 16 - k);
        frame_checks("R5 R6 random processor");
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule